// File: doc/BRIEF.md
# Trimmed Seconds Divider

This block turns a 32768 Hz oscillator enable into a one-per-second tick. A 3-bit sign-and-magnitude trim code corrects the average rate in 20 ppm steps, from -60 ppm to +60 ppm. The block does not change every second. An error accumulator collects the fractional cycle error at each second boundary. When that error reaches a whole input cycle, the next second is made shorter or longer by the number of whole cycles owed. Over many seconds the average count per second then matches the trim setting.

The block runs in the fast system clock domain. `osc_en` marks each oscillator cycle, and only those cycles are counted. The trim code is sampled only at second boundaries. A new code takes effect for the following second and starts the error accumulation afresh. Each tick is flagged when the second it closes was a corrected one.

Top module: `trimdiv_sec`

## Requirements
- R1: After synchronous reset `sec_tick` and `trim_sec` are 0, the active code is 000, and the first second lasts exactly DIV (32768) enabled cycles.
- R2: `sec_tick` is a one-clock pulse. It is asserted in the clock after the `osc_en` cycle that completes a second. Clocks with `osc_en` low do not advance the count.
- R3: Trim code bit 2 is the sign (0 = positive compensation, 1 = negative). Bit 1 is worth 40 ppm and bit 0 is worth 20 ppm, and the magnitude is their sum. Codes 000 and 100 both give zero compensation, so every second lasts DIV cycles. A 20 ppm code builds up less than one cycle of error in the first second after a change.
- R4: At each boundary where the code is unchanged, magnitude × DIV is added to an accumulator scaled so that SCALE (1,000,000) equals one cycle. The whole count k = floor(sum / SCALE) is removed and the remainder is kept. k can reach 2 at 60 ppm.
- R5: With positive compensation the next second lasts DIV − k enabled cycles. With negative compensation it lasts DIV + k.
- R6: `trim_sec` is high together with `sec_tick` exactly when the second just closed had k ≠ 0. Otherwise it is 0.
- R7: If the trim input differs from the active code at a boundary, the input becomes the active code, the accumulator is cleared, and the following second is uncorrected.
- R8: The trim input is sampled only at boundaries. A code applied in mid-second does not alter the length of that second. A change that is reverted before the boundary has no effect on the accumulator or on later seconds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_en | input | 1 | One-clock marker of each oscillator cycle |
| trim_code | input | 3 | Trim code: bit 2 sign, bit 1 = 40 ppm, bit 0 = 20 ppm |
| sec_tick | output | 1 | One-clock pulse per second |
| trim_sec | output | 1 | High with `sec_tick` when the closing second was corrected |

## Verification
Both outputs are registered. `sec_tick` and `trim_sec` rise in the clock that follows the rising edge at which the final enabled cycle of a second is counted. A trim code sampled at a boundary first changes a length one whole second later. The bench changes inputs on falling edges and compares both outputs on every falling edge against a behavioural model that steps at the same rising edge. Hand-derived second lengths, measured in enabled cycles between ticks, check the accumulation across code changes, mid-second glitches and gated enables.

// File: rtl/trimdiv_pkg.sv
package trimdiv_pkg;

    localparam int TRIM_W = 3;

    typedef struct packed {
        logic       neg;
        logic [1:0] steps;
    } trim_code_t;

    // largest whole-cycle correction one second can owe
    function automatic int kmax_f(int div, int scale, int step_ppm);
        return (scale - 1 + 3 * step_ppm * div) / scale;
    endfunction

    // bits needed to hold values 0 .. n-1
    function automatic int bits_f(int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/trimdiv_accum.sv
module trimdiv_accum
    import trimdiv_pkg::*;
#(
    parameter int DIV      = 32768,
    parameter int SCALE    = 1000000,
    parameter int STEP_PPM = 20,
    parameter int K_MAX    = kmax_f(DIV, SCALE, STEP_PPM),
    parameter int K_W      = bits_f(K_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           boundary,
    input  trim_code_t     trim_in,
    output logic [K_W-1:0] corr_k,
    output logic           corr_neg
);

    localparam int ACC_W = bits_f(SCALE + 3 * STEP_PPM * DIV);
    localparam logic [ACC_W-1:0] UNIT_INC = ACC_W'(STEP_PPM * DIV);
    localparam logic [ACC_W-1:0] SCALE_V  = ACC_W'(SCALE);

    typedef struct packed {
        trim_code_t       code;
        logic [ACC_W-1:0] acc;
        logic [K_W-1:0]   k;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W-1:0] inc, sum, rem;
    logic [K_W-1:0]   k_new;

    always_comb begin
        st_d  = st_q;
        inc   = UNIT_INC * ACC_W'(st_q.code.steps);
        sum   = st_q.acc + inc;
        k_new = '0;
        for (int i = 1; i <= K_MAX; i++) begin
            if (sum >= ACC_W'(i * SCALE)) k_new = K_W'(i);
        end
        rem = sum - ACC_W'(k_new) * SCALE_V;
        if (boundary) begin
            if (trim_in != st_q.code) begin
                st_d.code = trim_in;
                st_d.acc  = '0;
                st_d.k    = '0;
            end else begin
                st_d.acc  = rem;
                st_d.k    = k_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign corr_k   = st_q.k;
    assign corr_neg = st_q.code.neg;

    // R4
    acc_below_scale_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.acc < SCALE_V);

    // R7
    change_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(boundary) && ($past(trim_in) != $past(st_q.code)))
        |-> (st_q.acc == '0 && st_q.k == '0 && st_q.code == $past(trim_in)));

    // R3
    zero_mag_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.code.steps == 2'b00) |-> (st_q.k == '0));

    // R8
    hold_mid_second_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(boundary)) |-> $stable(st_q));

endmodule

// File: rtl/trimdiv_count.sv
module trimdiv_count #(
    parameter int DIV   = 32768,
    parameter int K_MAX = 2,
    parameter int K_W   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           osc_en,
    input  logic [K_W-1:0] corr_k,
    input  logic           corr_neg,
    output logic           boundary,
    output logic           tick,
    output logic           corr_sec
);

    localparam int CNT_W = trimdiv_pkg::bits_f(DIV + K_MAX);
    localparam logic [CNT_W-1:0] NOM_LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
        logic             corr;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last     = corr_neg ? (NOM_LAST + CNT_W'(corr_k)) : (NOM_LAST - CNT_W'(corr_k));
        boundary = osc_en && (st_q.cnt == last);
        st_d      = st_q;
        st_d.tick = boundary;
        st_d.corr = boundary && (corr_k != '0);
        if (osc_en) st_d.cnt = boundary ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick     = st_q.tick;
    assign corr_sec = st_q.corr;

    // R2
    tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.tick |=> !st_q.tick);

    // R6
    corr_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.corr |-> st_q.tick);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_W'(DIV - 1 + K_MAX));

    // R5
    corr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(boundary)) |-> ($stable(corr_k) && $stable(corr_neg)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(osc_en)) |-> ($stable(st_q.cnt) && !st_q.tick));

endmodule

// File: rtl/trimdiv_sec.sv
module trimdiv_sec
    import trimdiv_pkg::*;
#(
    parameter int DIV      = 32768,
    parameter int SCALE    = 1000000,
    parameter int STEP_PPM = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_en,
    input  logic [TRIM_W-1:0] trim_code,
    output logic              sec_tick,
    output logic              trim_sec
);

    localparam int K_MAX = kmax_f(DIV, SCALE, STEP_PPM);
    localparam int K_W   = bits_f(K_MAX + 1);

    logic           boundary;
    logic [K_W-1:0] corr_k;
    logic           corr_neg;
    trim_code_t     code_in;

    assign code_in = trim_code_t'(trim_code);

    trimdiv_accum #(
        .DIV(DIV), .SCALE(SCALE), .STEP_PPM(STEP_PPM), .K_MAX(K_MAX), .K_W(K_W)
    ) accum_i (
        .clk(clk), .rst(rst), .boundary(boundary), .trim_in(code_in),
        .corr_k(corr_k), .corr_neg(corr_neg)
    );

    trimdiv_count #(
        .DIV(DIV), .K_MAX(K_MAX), .K_W(K_W)
    ) count_i (
        .clk(clk), .rst(rst), .osc_en(osc_en), .corr_k(corr_k), .corr_neg(corr_neg),
        .boundary(boundary), .tick(sec_tick), .corr_sec(trim_sec)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sec_tick && !trim_sec));

endmodule

// File: tb/trimdiv_sec_tb.sv
module trimdiv_sec_tb_top;

    localparam int DIV_T = 1024;
    localparam int SC_T  = 31250;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_en = 1'b1;
    logic [2:0] trim_r = 3'b000;
    logic sec_tick, trim_sec, full_tick, full_trim;

    always #4 clk = ~clk;

    trimdiv_sec #(.DIV(DIV_T), .SCALE(SC_T), .STEP_PPM(20)) dut_i (
        .clk(clk), .rst(rst), .osc_en(osc_en), .trim_code(trim_r),
        .sec_tick(sec_tick), .trim_sec(trim_sec)
    );

    trimdiv_sec dut_full (
        .clk(clk), .rst(rst), .osc_en(1'b1), .trim_code(3'b000),
        .sec_tick(full_tick), .trim_sec(full_trim)
    );

    int checks = 0, errors = 0;
    bit gate = 0;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // enable source, changed on falling edges
    always @(negedge clk) begin
        lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        osc_en <= gate ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // behavioural reference model
    int m_cnt, m_len, m_acc, m_k, m_code;
    bit exp_tick, exp_corr;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_len = DIV_T; m_acc = 0; m_k = 0; m_code = 0;
            exp_tick = 0; exp_corr = 0;
        end else begin
            exp_tick = 0; exp_corr = 0;
            if (osc_en) begin
                if (m_cnt == m_len - 1) begin
                    exp_tick = 1;
                    exp_corr = (m_k != 0);
                    m_cnt = 0;
                    if (int'(trim_r) != m_code) begin
                        m_code = int'(trim_r); m_acc = 0; m_k = 0;
                    end else begin
                        m_acc = m_acc + (m_code % 4) * 20 * DIV_T;
                        m_k   = m_acc / SC_T;
                        m_acc = m_acc % SC_T;
                    end
                    m_len = (m_code >= 4) ? DIV_T + m_k : DIV_T - m_k;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // enabled-cycle counter, edge counter for the full-size instance
    int ecount = 0, last_e = 0, edges = 0, first_full = 0;
    always @(posedge clk) begin
        if (rst) begin ecount = 0; edges = 0; end
        else begin
            edges++;
            if (osc_en) ecount++;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(sec_tick == exp_tick, "R2 tick vs model", int'(sec_tick), int'(exp_tick));
            chk(trim_sec == exp_corr, "R6 trim_sec vs model", int'(trim_sec), int'(exp_corr));
            if (full_tick && first_full == 0) first_full = edges;
        end
    end

    task automatic exp_sec(int elen, string req);
        int len;
        bit corr;
        do @(negedge clk); while (!sec_tick);
        corr = trim_sec;
        len = ecount - last_e;
        last_e = ecount;
        chk(len == elen, {req, " second length"}, len, elen);
        chk(corr == (elen != DIV_T), {req, " corrected flag"}, int'(corr), int'(elen != DIV_T));
    endtask

    task automatic set_trim_mid(logic [2:0] c);
        repeat (300) @(negedge clk);
        trim_r = c;
    endtask

    bit timeout = 0;

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst = 1'b0;
                // R1 reset state
                chk(sec_tick == 1'b0, "R1 reset tick", int'(sec_tick), 0);
                chk(trim_sec == 1'b0, "R1 reset trim_sec", int'(trim_sec), 0);
                exp_sec(1024, "R1");
                set_trim_mid(3'b011);
                exp_sec(1024, "R8");
                exp_sec(1024, "R7");
                exp_sec(1023, "R5");
                exp_sec(1022, "R4");
                exp_sec(1022, "R4");
                set_trim_mid(3'b110);
                exp_sec(1022, "R8");
                exp_sec(1024, "R7");
                exp_sec(1025, "R5");
                exp_sec(1025, "R5");
                exp_sec(1025, "R4");
                exp_sec(1026, "R4");
                // glitch reverted before the boundary
                set_trim_mid(3'b000);
                repeat (100) @(negedge clk);
                trim_r = 3'b110;
                exp_sec(1025, "R8");
                exp_sec(1025, "R8");
                set_trim_mid(3'b100);
                exp_sec(1026, "R8");
                exp_sec(1024, "R7");
                exp_sec(1024, "R3");
                exp_sec(1024, "R3");
                set_trim_mid(3'b000);
                exp_sec(1024, "R3");
                exp_sec(1024, "R3");
                exp_sec(1024, "R3");
                gate = 1;
                set_trim_mid(3'b101);
                exp_sec(1024, "R2");
                exp_sec(1024, "R7");
                exp_sec(1024, "R3");
                exp_sec(1025, "R5");
                exp_sec(1024, "R4");
                exp_sec(1025, "R4");
                wait (edges > 32770);
                @(negedge clk);
                chk(first_full == 32768, "R1 full-size first tick edge", first_full, 32768);
            end
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
            end
        join_any
        disable fork;
        if (timeout) chk(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule